// File: doc/BRIEF.md
# Variable Page-Size Translation Buffer

This block is a four-entry, fully associative address translation buffer that software fills by hand. Every entry carries a linear tag, a physical base, a valid flag and its own size mask over the page-number bits. The mask lets a single entry cover any power-of-two region from a 4 KiB page up to the whole 4 GiB linear space. Address bits that the mask leaves out, and the 12-bit page offset, pass straight through to the physical address.

Software reaches the entries through two registers. The data register holds a valid flag and a physical base. The command register names an entry, an operation, a linear tag and a mask. A write command loads the named entry in one clock edge. It takes the tag and mask from the command and the base and valid flag from the data register as they stood before that edge. A read command copies the named entry back. Its valid flag and base go into the data register, and its tag and stored mask go into a readback register.

The lookup port is purely combinational. It takes a 32-bit linear address and returns a hit flag and the translated physical address in the same cycle.

Top module: `masked_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and the data register and the tag/mask readback read as zero.
- R2: A pulse on `dat_we` loads `dat_valid` and `dat_pbase` into the data register, and they show on `dr_valid` and `dr_pbase` after that edge.
- R3: A command with `cmd_we`=1 and `cmd_op`=1 (write) loads entry `cmd_idx` at that edge. The tag comes from `cmd_tag`, the mask from `cmd_mask` and the base and valid flag from the data register, and lookups see the new entry in the very next cycle.
- R4: A valid entry hits when the linear page number (address bits 31:12) equals its tag on every bit whose mask bit is 1. An all-zero mask therefore matches any address, and an all-ones mask needs an exact match.
- R5: On a hit, physical bits 31:12 take the entry base where the mask is 1 and the linear address where it is 0, and physical bits 11:0 equal linear bits 11:0.
- R6: A mask whose leading k bits are 1 maps a region of 2^(32-k) bytes. With mask 0xFFC00 the entry covers a 4 MiB window, and both the first and the last byte of that window translate.
- R7: When several valid entries hit, the entry with the lowest index supplies the translation.
- R8: When no valid entry matches, `lk_hit` is 0 and `lk_paddr` is 0. An entry written with its valid flag at 0 never hits.
- R9: A command with `cmd_we`=1 and `cmd_op`=0 (read) loads entry `cmd_idx`'s valid flag and base into the data register and its tag and stored mask into `rb_tag`/`rb_mask` at that edge. No entry changes.
- R10: The stored mask keeps only the unbroken run of 1s that starts at the top bit (address bit 31). Every bit below the first 0 is stored as 0, so a written mask of 0xF0F00 is stored and compared as 0xF0000.
- R11: When a read command and `dat_we` occur in the same cycle, the data register takes the entry contents and the `dat_*` values are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dat_we | input | 1 | Data register write strobe |
| dat_valid | input | 1 | Valid flag to stage |
| dat_pbase | input | 20 | Physical page base to stage |
| cmd_we | input | 1 | Command strobe |
| cmd_op | input | 1 | 1 = write entry, 0 = read entry |
| cmd_idx | input | 2 | Entry index |
| cmd_tag | input | 20 | Linear tag (address bits 31:12) |
| cmd_mask | input | 20 | Size mask over address bits 31:12, 1 = compared |
| dr_valid | output | 1 | Data register valid flag |
| dr_pbase | output | 20 | Data register physical base |
| rb_tag | output | 20 | Tag of the entry last read |
| rb_mask | output | 20 | Stored mask of the entry last read |
| lk_addr | input | 32 | Linear address to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 32 | Translated physical address, 0 on a miss |

## Verification
The lookup is driven by a table of addresses set against a fixed mix of entries. The mix holds a 4 KiB page, a 1 MiB page that contains it, a 4 MiB page and an invalid catch-all. The table probes the first and last bytes of each region and the first byte just past it, which separates a correct mask width from one bit too wide or too narrow. It also probes the address inside both overlapping pages, which exposes a wrong priority order. Directed cases then enable the all-zero mask, write a mask with a gap and check that the stored mask has no gap, both by readback and by a lookup that only the trimmed mask hits. They also collide a read command with a data register write and invalidate entries one at a time so that lookups fall through to the next entry and finally miss.

// File: rtl/mtlb_pkg.sv
package mtlb_pkg;
    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } tlb_op_e;
endpackage

// File: rtl/mtlb_mask_norm.sv
module mtlb_mask_norm #(
    parameter int W = 20
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] norm
);
    // Keep only the run of ones starting at the top bit.
    assign norm[W-1] = raw[W-1];
    for (genvar i = W - 2; i >= 0; i--) begin : g_chain
        assign norm[i] = raw[i] & norm[i+1];
    end
endmodule

// File: rtl/mtlb_entry.sv
module mtlb_entry #(
    parameter int VPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [VPN_W-1:0] w_tag,
    input  logic [VPN_W-1:0] w_mask,
    input  logic [VPN_W-1:0] w_pbase,
    input  logic             w_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [VPN_W-1:0] xlat,
    output logic             q_valid,
    output logic [VPN_W-1:0] q_tag,
    output logic [VPN_W-1:0] q_mask,
    output logic [VPN_W-1:0] q_pbase
);
    localparam logic [VPN_W-1:0] ONE = VPN_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_tag   <= '0;
            q_mask  <= '0;
            q_pbase <= '0;
        end else if (we) begin
            q_valid <= w_valid;
            q_tag   <= w_tag;
            q_mask  <= w_mask;
            q_pbase <= w_pbase;
        end
    end

    always_comb begin
        hit  = q_valid && (((lk_vpn ^ q_tag) & q_mask) == '0);
        xlat = (q_pbase & q_mask) | (lk_vpn & ~q_mask);
    end

    // R3: a write lands in the entry at the strobing edge
    assert_wr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q_valid == $past(w_valid)) && (q_tag == $past(w_tag))
               && (q_pbase == $past(w_pbase)));

    // R10: stored mask is always an unbroken run of ones from the top
    assert_mask_contig_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((~q_mask) & ((~q_mask) + ONE)) == '0);
endmodule

// File: rtl/mtlb_prio.sv
module mtlb_prio #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    // R7: at most one entry supplies the translation
    assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R7: the chosen entry is one that actually hit
    assert_grant_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
endmodule

// File: rtl/masked_tlb.sv
module masked_tlb
    import mtlb_pkg::*;
#(
    parameter int ENTRIES  = 4,
    parameter int VA_W     = 32,
    parameter int PG_SHIFT = 12,
    parameter int IDX_W    = $clog2(ENTRIES),
    parameter int VPN_W    = VA_W - PG_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dat_we,
    input  logic             dat_valid,
    input  logic [VPN_W-1:0] dat_pbase,
    input  logic             cmd_we,
    input  logic             cmd_op,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [VPN_W-1:0] cmd_tag,
    input  logic [VPN_W-1:0] cmd_mask,
    output logic             dr_valid,
    output logic [VPN_W-1:0] dr_pbase,
    output logic [VPN_W-1:0] rb_tag,
    output logic [VPN_W-1:0] rb_mask,
    input  logic [VA_W-1:0]  lk_addr,
    output logic             lk_hit,
    output logic [VA_W-1:0]  lk_paddr
);
    tlb_op_e          op;
    logic             do_wr;
    logic             do_rd;
    logic [VPN_W-1:0] mask_n;
    logic [VPN_W-1:0] lk_vpn;

    logic [ENTRIES-1:0] hit_v;
    logic [ENTRIES-1:0] gnt_v;
    logic [VPN_W-1:0]   xlat_a  [ENTRIES];
    logic               qv_a    [ENTRIES];
    logic [VPN_W-1:0]   qtag_a  [ENTRIES];
    logic [VPN_W-1:0]   qmask_a [ENTRIES];
    logic [VPN_W-1:0]   qpb_a   [ENTRIES];

    logic               sel_valid;
    logic [VPN_W-1:0]   sel_pbase;
    logic [VPN_W-1:0]   sel_tag;
    logic [VPN_W-1:0]   sel_mask;
    logic [VPN_W-1:0]   out_vpn;

    assign op     = tlb_op_e'(cmd_op);
    assign lk_vpn = lk_addr[VA_W-1:PG_SHIFT];

    // Command decode
    always_comb begin
        do_wr = 1'b0;
        do_rd = 1'b0;
        unique case (op)
            OP_WRITE: do_wr = cmd_we;
            OP_READ:  do_rd = cmd_we;
        endcase
    end

    mtlb_mask_norm #(.W(VPN_W)) u_norm (
        .raw  (cmd_mask),
        .norm (mask_n)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        mtlb_entry #(.VPN_W(VPN_W)) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (do_wr && (cmd_idx == IDX_W'(i))),
            .w_tag   (cmd_tag),
            .w_mask  (mask_n),
            .w_pbase (dr_pbase),
            .w_valid (dr_valid),
            .lk_vpn  (lk_vpn),
            .hit     (hit_v[i]),
            .xlat    (xlat_a[i]),
            .q_valid (qv_a[i]),
            .q_tag   (qtag_a[i]),
            .q_mask  (qmask_a[i]),
            .q_pbase (qpb_a[i])
        );
    end

    mtlb_prio #(.N(ENTRIES)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (hit_v),
        .gnt   (gnt_v)
    );

    // Lookup result
    always_comb begin
        out_vpn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (gnt_v[i]) out_vpn = out_vpn | xlat_a[i];
        end
        lk_hit   = |gnt_v;
        lk_paddr = lk_hit ? {out_vpn, lk_addr[PG_SHIFT-1:0]} : '0;
    end

    // Readback selection
    always_comb begin
        sel_valid = qv_a[cmd_idx];
        sel_pbase = qpb_a[cmd_idx];
        sel_tag   = qtag_a[cmd_idx];
        sel_mask  = qmask_a[cmd_idx];
    end

    // Data register and tag/mask readback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr_valid <= 1'b0;
            dr_pbase <= '0;
            rb_tag   <= '0;
            rb_mask  <= '0;
        end else if (do_rd) begin
            dr_valid <= sel_valid;
            dr_pbase <= sel_pbase;
            rb_tag   <= sel_tag;
            rb_mask  <= sel_mask;
        end else if (dat_we) begin
            dr_valid <= dat_valid;
            dr_pbase <= dat_pbase;
        end
    end

    // R8: a miss drives a zero address
    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0));

    // R5: the page offset passes through on a hit
    assert_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[PG_SHIFT-1:0] == lk_addr[PG_SHIFT-1:0]));

    // R9 / R11: a read command fills the data register from the entry
    assert_rd_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        do_rd |=> (dr_valid == $past(sel_valid)) && (dr_pbase == $past(sel_pbase)));
endmodule

// File: tb/sim_masked_tlb.sv
`timescale 1ns/1ps
module sim_masked_tlb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dat_we, dat_valid;
    logic [19:0] dat_pbase;
    logic        cmd_we, cmd_op;
    logic [1:0]  cmd_idx;
    logic [19:0] cmd_tag, cmd_mask;
    logic        dr_valid;
    logic [19:0] dr_pbase, rb_tag, rb_mask;
    logic [31:0] lk_addr;
    logic        lk_hit;
    logic [31:0] lk_paddr;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    masked_tlb u0 (
        .clk(clk), .rst_n(rst_n),
        .dat_we(dat_we), .dat_valid(dat_valid), .dat_pbase(dat_pbase),
        .cmd_we(cmd_we), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_tag(cmd_tag), .cmd_mask(cmd_mask),
        .dr_valid(dr_valid), .dr_pbase(dr_pbase),
        .rb_tag(rb_tag), .rb_mask(rb_mask),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_paddr(lk_paddr)
    );

    // {address, expected hit, expected physical address}
    localparam logic [64:0] VEC [10] = '{
        {32'h12345678, 1'b1, 32'hABCDE678},   // R7 entry0 beats entry3
        {32'h12346678, 1'b1, 32'h00746678},   // R5 1 MiB page
        {32'h123FFFFF, 1'b1, 32'h007FFFFF},   // R4 last byte of 1 MiB page
        {32'h12400000, 1'b0, 32'h00000000},   // R8 just past 1 MiB page
        {32'h40000000, 1'b1, 32'h80000000},   // R6 first byte of 4 MiB page
        {32'h403FFABC, 1'b1, 32'h803FFABC},   // R6 last page of 4 MiB window
        {32'h40400000, 1'b0, 32'h00000000},   // R6 just past 4 MiB window
        {32'h00000000, 1'b0, 32'h00000000},   // R8 invalid catch-all
        {32'hFFFFFFFF, 1'b0, 32'h00000000},   // R8
        {32'h3FFFFFFF, 1'b0, 32'h00000000}    // R8 just below 4 MiB window
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s got %h exp %h", req, act, exp);
        end
    endtask

    task automatic put_data(input logic v, input logic [19:0] pb);
        @(negedge clk);
        dat_we = 1'b1; dat_valid = v; dat_pbase = pb;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic put_cmd(input logic wr, input logic [1:0] idx,
                           input logic [19:0] tag, input logic [19:0] msk);
        @(negedge clk);
        cmd_we = 1'b1; cmd_op = wr; cmd_idx = idx; cmd_tag = tag; cmd_mask = msk;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic look(input string req, input logic [31:0] a,
                        input logic hit, input logic [31:0] pa);
        lk_addr = a;
        #1;
        chk(req, {31'd0, lk_hit}, {31'd0, hit});
        chk(req, lk_paddr, pa);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; dat_we = 0; dat_valid = 0; dat_pbase = '0;
        cmd_we = 0; cmd_op = 0; cmd_idx = '0; cmd_tag = '0; cmd_mask = '0;
        lk_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 dr_valid", {31'd0, dr_valid}, 32'd0);
        chk("R1 dr_pbase", {12'd0, dr_pbase}, 32'd0);
        chk("R1 rb_tag",   {12'd0, rb_tag},   32'd0);
        chk("R1 rb_mask",  {12'd0, rb_mask},  32'd0);
        look("R1 lookup zero", 32'h00000000, 1'b0, 32'h0);
        look("R1 lookup", 32'h12345678, 1'b0, 32'h0);

        // R2: data register write
        put_data(1'b1, 20'hABCDE);
        chk("R2 dr_valid", {31'd0, dr_valid}, 32'd1);
        chk("R2 dr_pbase", {12'd0, dr_pbase}, 32'h000ABCDE);

        // R3: program the entry mix
        put_cmd(1'b1, 2'd0, 20'h12345, 20'hFFFFF);
        look("R3 new entry visible", 32'h12345ABC, 1'b1, 32'hABCDEABC);
        put_data(1'b1, 20'h80000);
        put_cmd(1'b1, 2'd1, 20'h40000, 20'hFFC00);
        put_data(1'b0, 20'h55555);
        put_cmd(1'b1, 2'd2, 20'h00000, 20'h00000);
        put_data(1'b1, 20'h00700);
        put_cmd(1'b1, 2'd3, 20'h12300, 20'hFFF00);

        // Table walk: R4 R5 R6 R7 R8
        foreach (VEC[i]) begin
            look($sformatf("R4/R5/R6/R7/R8 vec%0d", i),
                 VEC[i][64:33], VEC[i][32], VEC[i][31:0]);
        end

        // R4 / R7: enable the all-zero mask catch-all in entry 2
        put_data(1'b1, 20'h55555);
        put_cmd(1'b1, 2'd2, 20'h00000, 20'h00000);
        look("R4 zero mask matches all", 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF);
        look("R7 entry2 beats entry3", 32'h12346678, 1'b1, 32'h12346678);
        look("R7 entry0 beats entry2", 32'h12345678, 1'b1, 32'hABCDE678);

        // R9: read back entry 3
        put_cmd(1'b0, 2'd3, 20'h0, 20'h0);
        chk("R9 dr_valid", {31'd0, dr_valid}, 32'd1);
        chk("R9 dr_pbase", {12'd0, dr_pbase}, 32'h00000700);
        chk("R9 rb_tag",   {12'd0, rb_tag},   32'h00012300);
        chk("R9 rb_mask",  {12'd0, rb_mask},  32'h000FFF00);
        look("R9 entries unchanged", 32'h12345678, 1'b1, 32'hABCDE678);

        // R10: a mask with a gap is trimmed
        put_data(1'b1, 20'h55555);
        put_cmd(1'b1, 2'd2, 20'hA0000, 20'hF0F00);
        look("R10 trimmed mask lookup", 32'hA1234000, 1'b1, 32'h51234000);
        put_cmd(1'b0, 2'd2, 20'h0, 20'h0);
        chk("R10 rb_mask", {12'd0, rb_mask}, 32'h000F0000);

        // R11: read wins over a same-cycle data write
        @(negedge clk);
        cmd_we = 1'b1; cmd_op = 1'b0; cmd_idx = 2'd0;
        dat_we = 1'b1; dat_valid = 1'b0; dat_pbase = 20'h11111;
        @(negedge clk);
        cmd_we = 1'b0; dat_we = 1'b0;
        chk("R11 dr_valid", {31'd0, dr_valid}, 32'd1);
        chk("R11 dr_pbase", {12'd0, dr_pbase}, 32'h000ABCDE);

        // R8: invalidate entries; lookup falls through then misses
        put_data(1'b0, 20'h00000);
        put_cmd(1'b1, 2'd0, 20'h12345, 20'hFFFFF);
        look("R8 falls to entry3", 32'h12345678, 1'b1, 32'h00745678);
        put_cmd(1'b1, 2'd3, 20'h12300, 20'hFFF00);
        look("R8 invalid entries miss", 32'h12345678, 1'b0, 32'h00000000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule